// File: doc/BRIEF.md
# Multichannel Peripheral DMA Controller

This block moves single data items between memory and peripherals for up to seven peripheral request lines. Each channel is set up through a small write-only configuration port with a source address, a destination address, an item count, a direction, one increment enable per address, and a 2-bit priority. A peripheral raises its request line when it has data or space. The controller samples the line in that same cycle, because the peripherals run on the controller's clock. It picks the highest-priority eligible channel and then runs one read access followed by one write access on a shared single-master bus.

Each peripheral receives its acknowledge in the cycle its own side of the transfer completes. For a memory-to-peripheral channel that is the write. For a peripheral-to-memory channel it is the read. After each item the channel's count goes down by one. When the count reaches zero the channel raises a done flag and disables itself. An error response on either access stops the channel and raises an error flag.

Top module: `pdma_ctrl`

## Requirements
- R1: There are `NCH` (default 7) channels. Each has its own request input `dreq[i]` and acknowledge output `dack[i]`. At most one acknowledge is high in any cycle, and none is high after reset.
- R2: A request is sampled with no synchronisation delay. When the controller is idle and an eligible request is high during a cycle, the read access for that channel is presented on the bus in the next cycle.
- R3: An eligible channel is enabled, has its request high and has a nonzero count. Among eligible channels, the one with the larger priority value (control bits 5:4) is served first. On equal priority, the lower channel number wins.
- R4: Each item is one read at the channel's source address. It is followed in the next bus cycle by one write of the same data to the channel's destination address. The bus returns to idle for at least one cycle after the write.
- R5: The acknowledge is high exactly in the cycle the peripheral-side access completes without error (`bus_req`, `bus_ready` and no `bus_err`). When control bit 1 is 1 (memory to peripheral), that access is the write. When bit 1 is 0 (peripheral to memory), it is the read.
- R6: After each completed item, the source address advances by `ITEM_BYTES` if control bit 2 is set, and the destination address advances by `ITEM_BYTES` if control bit 3 is set. An address whose bit is clear stays fixed.
- R7: The count decrements after each completed item. When it reaches zero, `done_flags[i]` is set and the channel clears its enable bit (control bit 0), so further requests on that line are not served.
- R8: An error response on either access sets `err_flags[i]` and clears the channel's enable bit. No acknowledge is given for that item. A read error issues no write.
- R9: While `bus_ready` is low, the pending access holds `bus_req`, `bus_we` and `bus_addr` unchanged.
- R10: Configuration writes select a field with `cfg_sel`: 0 source, 1 destination, 2 count, 3 control, 4 flag clear. A clear write to a channel zeroes its done and error flags only. An enabled channel with a count of zero is never served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the peripherals |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 3 | Channel selected for the write |
| cfg_sel | input | 3 | Field selected for the write |
| cfg_wdata | input | 32 | Configuration write data |
| dreq | input | 7 | Peripheral request lines, one per channel |
| dack | output | 7 | Peripheral acknowledge lines, one per channel |
| bus_req | output | 1 | Bus access valid |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Access address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ready` |
| bus_ready | input | 1 | Access completes this cycle |
| bus_err | input | 1 | Error response for the completing access |
| done_flags | output | 7 | Per-channel transfer-complete flags |
| err_flags | output | 7 | Per-channel bus-error flags |

## Verification
The bench builds the controller with its defaults: seven channels, 4-byte items and a 16-bit count. Every request line can therefore be driven, and two channels can share the top priority value, which makes the lower-number tie-break observable. Small counts of one to three items reach the count-to-zero disable within a few cycles. A bus model that toggles ready on alternate cycles exercises held accesses. An address window that answers with an error reaches both the read-phase abort and the write-phase abort.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int PRIO_W = 2;
    localparam int NUM_CH = 7;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_SRC  = 3'd0,
        SEL_DST  = 3'd1,
        SEL_CNT  = 3'd2,
        SEL_CTRL = 3'd3,
        SEL_CLR  = 3'd4
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic              en;
        logic              to_periph;
        logic              src_inc;
        logic              dst_inc;
        logic [PRIO_W-1:0] prio;
    } chan_cfg_t;

    function automatic logic [ADDR_W-1:0] step_addr(
        input logic [ADDR_W-1:0] a, input logic inc, input int unsigned bytes);
        return inc ? a + ADDR_W'(bytes) : a;
    endfunction
endpackage

// File: rtl/pdma_chan.sv
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int ITEM_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step,
    input  logic              abort,
    output chan_cfg_t         cfg,
    output logic              done,
    output logic              err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg  <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            if (step) begin
                cfg.src <= step_addr(cfg.src, cfg.src_inc, ITEM_BYTES);
                cfg.dst <= step_addr(cfg.dst, cfg.dst_inc, ITEM_BYTES);
                cfg.cnt <= cfg.cnt - CNT_W'(1);
                if (cfg.cnt == CNT_W'(1)) begin
                    done   <= 1'b1;
                    cfg.en <= 1'b0;
                end
            end
            if (abort) begin
                err    <= 1'b1;
                cfg.en <= 1'b0;
            end
            if (wr_en) begin
                case (cfg_sel_e'(wr_sel))
                    SEL_SRC: cfg.src <= wr_data[ADDR_W-1:0];
                    SEL_DST: cfg.dst <= wr_data[ADDR_W-1:0];
                    SEL_CNT: cfg.cnt <= wr_data[CNT_W-1:0];
                    SEL_CTRL: begin
                        cfg.en        <= wr_data[0];
                        cfg.to_periph <= wr_data[1];
                        cfg.src_inc   <= wr_data[2];
                        cfg.dst_inc   <= wr_data[3];
                        cfg.prio      <= wr_data[4 +: PRIO_W];
                    end
                    SEL_CLR: begin
                        done <= 1'b0;
                        err  <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pdma_arb.sv
module pdma_arb
    import pdma_pkg::*;
#(
    parameter int NCH = 7,
    parameter int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0]        elig,
    input  logic [NCH*PRIO_W-1:0] prio_flat,
    output logic                  gnt_vld,
    output logic [CHW-1:0]        gnt_idx
);
    logic [PRIO_W-1:0] best;

    // Strict greater-than keeps the lowest index among equal priorities.
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        best    = '0;
        for (int i = 0; i < NCH; i++) begin
            if (elig[i] && (!gnt_vld || prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
                gnt_vld = 1'b1;
                gnt_idx = CHW'(i);
                best    = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
    import pdma_pkg::*;
#(
    parameter int CHW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gnt_vld,
    input  logic [CHW-1:0]    gnt_idx,
    input  logic [ADDR_W-1:0] cur_src,
    input  logic [ADDR_W-1:0] cur_dst,
    input  logic              cur_to_periph,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    input  logic              bus_err,
    output logic [CHW-1:0]    cur_idx,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              item_done,
    output logic              item_abort,
    output logic              periph_beat
);
    seq_state_e        state;
    logic [DATA_W-1:0] hold_data;
    logic              finish;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_idx   <= '0;
            hold_data <= '0;
        end else begin
            case (state)
                ST_IDLE: if (gnt_vld) begin
                    cur_idx <= gnt_idx;
                    state   <= ST_READ;
                end
                ST_READ: if (bus_ready) begin
                    if (bus_err) state <= ST_IDLE;
                    else begin
                        hold_data <= bus_rdata;
                        state     <= ST_WRITE;
                    end
                end
                ST_WRITE: if (bus_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req     = (state != ST_IDLE);
        bus_we      = (state == ST_WRITE);
        bus_addr    = bus_we ? cur_dst : cur_src;
        bus_wdata   = hold_data;
        finish      = bus_req && bus_ready;
        item_done   = finish && bus_we && !bus_err;
        item_abort  = finish && bus_err;
        periph_beat = finish && !bus_err && (bus_we == cur_to_periph);
    end
endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
    import pdma_pkg::*;
#(
    parameter int NCH        = NUM_CH,
    parameter int ITEM_BYTES = 4,
    parameter int CHW        = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_chan,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [NCH-1:0]    dreq,
    output logic [NCH-1:0]    dack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    input  logic              bus_err,
    output logic [NCH-1:0]    done_flags,
    output logic [NCH-1:0]    err_flags
);
    chan_cfg_t             cfgs [NCH];
    logic [NCH-1:0]        elig;
    logic [NCH*PRIO_W-1:0] prio_flat;
    logic                  gnt_vld;
    logic [CHW-1:0]        gnt_idx;
    logic [CHW-1:0]        cur_idx;
    logic                  item_done, item_abort, periph_beat;
    chan_cfg_t             cur_cfg;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pdma_chan #(.ITEM_BYTES(ITEM_BYTES)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (cfg_we && (cfg_chan == CHW'(g))),
            .wr_sel  (cfg_sel),
            .wr_data (cfg_wdata),
            .step    (item_done && (cur_idx == CHW'(g))),
            .abort   (item_abort && (cur_idx == CHW'(g))),
            .cfg     (cfgs[g]),
            .done    (done_flags[g]),
            .err     (err_flags[g])
        );
        assign elig[g] = cfgs[g].en && dreq[g] && (cfgs[g].cnt != '0);
        assign prio_flat[g*PRIO_W +: PRIO_W] = cfgs[g].prio;
    end

    pdma_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
        .elig      (elig),
        .prio_flat (prio_flat),
        .gnt_vld   (gnt_vld),
        .gnt_idx   (gnt_idx)
    );

    always_comb begin
        cur_cfg = '0;
        for (int i = 0; i < NCH; i++)
            if (cur_idx == CHW'(i)) cur_cfg = cfgs[i];
    end

    pdma_seq #(.CHW(CHW)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .gnt_vld       (gnt_vld),
        .gnt_idx       (gnt_idx),
        .cur_src       (cur_cfg.src),
        .cur_dst       (cur_cfg.dst),
        .cur_to_periph (cur_cfg.to_periph),
        .bus_rdata     (bus_rdata),
        .bus_ready     (bus_ready),
        .bus_err       (bus_err),
        .cur_idx       (cur_idx),
        .bus_req       (bus_req),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .item_done     (item_done),
        .item_abort    (item_abort),
        .periph_beat   (periph_beat)
    );

    assign dack = periph_beat ? (NCH'(1) << cur_idx) : '0;
endmodule

// File: rtl/pdma_checker.sv
module pdma_checker
    import pdma_pkg::*;
#(
    parameter int NCH = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    dack,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic              bus_err
);
    p_ack_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    p_ack_on_good_beat_r5: assert property (@(posedge clk) disable iff (rst)
        (dack != '0) |-> (bus_req && bus_ready && !bus_err));

    p_no_ack_on_error_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_err) |-> (dack == '0));

    p_read_abort_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ready && bus_err) |=> !bus_req);

    p_write_follows_read_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_ready && !bus_err) |=> (bus_req && bus_we));

    p_idle_after_write_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_ready) |=> !bus_req);

    p_hold_while_stalled_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));
endmodule

bind pdma_ctrl pdma_checker #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dack      (dack),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_ready (bus_ready),
    .bus_err   (bus_err)
);

// File: tb/tb_pdma_ctrl.sv
module tb_pdma_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_chan = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [NCH-1:0] dreq, dack, done_flags, err_flags;
    logic        bus_req, bus_we, bus_ready, bus_err;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    int checks = 0;
    int fails = 0;
    int raised [NCH];
    int acked [NCH];
    bit dir_exp [NCH];
    logic        stall_mode = 1'b0;
    logic        stall_ph = 1'b0;

    logic [31:0] exp_addr_q[$];
    logic [31:0] exp_data_q[$];
    string       exp_tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pdma_ctrl dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .done_flags(done_flags), .err_flags(err_flags)
    );

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    // Bus model: error window at 0xE000_0000, optional alternate-cycle stall.
    assign bus_rdata = mem_val(bus_addr);
    assign bus_err   = bus_req && (bus_addr[31:28] == 4'hE);
    assign bus_ready = !stall_ph;

    always @(posedge clk) stall_ph <= stall_mode ? ~stall_ph : 1'b0;

    // Peripheral model: a request stays high until every raised item is acknowledged.
    initial for (int i = 0; i < NCH; i++) begin raised[i] = 0; acked[i] = 0; dir_exp[i] = 1'b0; end
    always_comb for (int i = 0; i < NCH; i++) dreq[i] = (raised[i] != acked[i]);
    always @(posedge clk) if (!rst) for (int i = 0; i < NCH; i++) if (dack[i]) acked[i] <= acked[i] + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    // Monitor: scoreboard pop on every good write; acknowledge placement check.
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_req && bus_we && bus_ready && !bus_err) begin
                if (exp_addr_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected write addr", bus_addr, 32'h0);
                end else begin
                    logic [31:0] ea, ed;
                    string t;
                    ea = exp_addr_q.pop_front();
                    ed = exp_data_q.pop_front();
                    t  = exp_tag_q.pop_front();
                    check(bus_addr == ea, t, "write addr", bus_addr, ea);
                    check(bus_wdata == ed, t, "write data (R4)", bus_wdata, ed);
                end
            end
            for (int i = 0; i < NCH; i++) begin
                if (dack[i]) begin
                    check(bus_req && bus_ready && !bus_err && (bus_we == dir_exp[i]),
                          "R5", $sformatf("ack ch%0d side", i), {31'd0, bus_we}, {31'd0, dir_exp[i]});
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input int ch, input logic [2:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_chan = 3'(ch); cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic program_ch(input int ch, input logic [31:0] src, input logic [31:0] dst,
                              input int cnt, input bit to_p, input bit sinc, input bit dinc,
                              input logic [1:0] prio);
        dir_exp[ch] = to_p;
        cfg_write(ch, 3'd0, src);
        cfg_write(ch, 3'd1, dst);
        cfg_write(ch, 3'd2, 32'(cnt));
        cfg_write(ch, 3'd3, {26'd0, prio, dinc, sinc, to_p, 1'b1});
    endtask

    task automatic expect_write(input logic [31:0] a, input logic [31:0] d, input string tag);
        exp_addr_q.push_back(a);
        exp_data_q.push_back(d);
        exp_tag_q.push_back(tag);
    endtask

    task automatic settle(input int n);
        repeat (n) tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);
        check(dack == '0, "R1", "ack after reset", 32'(dack), 0);
        check(bus_req == 1'b0, "R4", "bus idle after reset", {31'd0, bus_req}, 0);
        check(done_flags == '0 && err_flags == '0, "R7", "flags after reset",
              {16'(done_flags), 16'(err_flags)}, 0);

        // Memory to peripheral, source increments, destination fixed.
        program_ch(2, 32'h0000_1000, 32'h4000_0000, 3, 1, 1, 0, 2'd1);
        expect_write(32'h4000_0000, mem_val(32'h1000), "R6");
        expect_write(32'h4000_0000, mem_val(32'h1004), "R6");
        expect_write(32'h4000_0000, mem_val(32'h1008), "R6");
        raised[2] = raised[2] + 3;
        @(negedge clk);
        check(bus_req == 1'b0, "R2", "no access before sampling edge", {31'd0, bus_req}, 0);
        @(negedge clk);
        check(bus_req && !bus_we && bus_addr == 32'h1000, "R2", "read one cycle after request",
              bus_addr, 32'h1000);
        settle(30);
        check(acked[2] == 3, "R5", "acks on ch2", 32'(acked[2]), 3);
        check(done_flags[2] == 1'b1, "R7", "done ch2", {31'd0, done_flags[2]}, 1);
        raised[2] = raised[2] + 1;
        settle(10);
        check(acked[2] == 3, "R7", "disabled ch2 not served", 32'(acked[2]), 3);
        check(exp_addr_q.size() == 0, "R4", "ch2 writes drained", 32'(exp_addr_q.size()), 0);

        // Peripheral to memory, source fixed, destination increments.
        program_ch(5, 32'h4000_0010, 32'h0000_2000, 2, 0, 0, 1, 2'd3);
        expect_write(32'h0000_2000, mem_val(32'h4000_0010), "R6");
        expect_write(32'h0000_2004, mem_val(32'h4000_0010), "R6");
        raised[5] = raised[5] + 2;
        settle(20);
        check(acked[5] == 2, "R5", "acks on ch5 at read", 32'(acked[5]), 2);
        check(done_flags[5] == 1'b1, "R7", "done ch5", {31'd0, done_flags[5]}, 1);

        // Priority and tie-break: ch3 and ch4 at 2, ch1 at 0.
        program_ch(1, 32'h0000_1200, 32'h0000_5000, 1, 1, 1, 1, 2'd0);
        program_ch(3, 32'h0000_1300, 32'h0000_5100, 1, 1, 1, 1, 2'd2);
        program_ch(4, 32'h0000_1400, 32'h0000_5200, 1, 1, 1, 1, 2'd2);
        expect_write(32'h0000_5100, mem_val(32'h1300), "R3");
        expect_write(32'h0000_5200, mem_val(32'h1400), "R3");
        expect_write(32'h0000_5000, mem_val(32'h1200), "R3");
        raised[1] = raised[1] + 1;
        raised[3] = raised[3] + 1;
        raised[4] = raised[4] + 1;
        settle(25);
        check(exp_addr_q.size() == 0, "R3", "priority writes drained", 32'(exp_addr_q.size()), 0);

        // Wait states on alternate cycles.
        stall_mode = 1'b1;
        program_ch(4, 32'h0000_1800, 32'h0000_6000, 2, 1, 1, 1, 2'd0);
        expect_write(32'h0000_6000, mem_val(32'h1800), "R9");
        expect_write(32'h0000_6004, mem_val(32'h1804), "R9");
        raised[4] = raised[4] + 2;
        settle(40);
        check(acked[4] == 3, "R9", "acks on ch4 with stalls", 32'(acked[4]), 3);
        stall_mode = 1'b0;
        settle(2);

        // Read-side error.
        program_ch(0, 32'hE000_0000, 32'h0000_3000, 2, 1, 1, 1, 2'd0);
        raised[0] = raised[0] + 1;
        settle(15);
        check(err_flags[0] == 1'b1, "R8", "read error flag", {31'd0, err_flags[0]}, 1);
        check(acked[0] == 0, "R8", "no ack on read error", 32'(acked[0]), 0);
        check(done_flags[0] == 1'b0, "R8", "no done on read error", {31'd0, done_flags[0]}, 0);

        // Write-side error.
        program_ch(6, 32'h0000_1100, 32'hE000_0100, 2, 1, 1, 0, 2'd0);
        raised[6] = raised[6] + 1;
        settle(15);
        check(err_flags[6] == 1'b1, "R8", "write error flag", {31'd0, err_flags[6]}, 1);
        check(acked[6] == 0, "R8", "no ack on write error", 32'(acked[6]), 0);

        // Enabled channel with zero count is ignored.
        cfg_write(3, 3'd3, 32'h0000_0003);
        raised[3] = raised[3] + 1;
        @(negedge clk);
        check(bus_req == 1'b0, "R10", "zero count not granted", {31'd0, bus_req}, 0);
        settle(10);
        check(acked[3] == 1, "R10", "zero count no ack", 32'(acked[3]), 1);

        // Flag clear is per channel.
        cfg_write(0, 3'd4, 32'h0);
        @(negedge clk);
        check(err_flags == 7'b1000000, "R10", "err flags after clear", 32'(err_flags), 32'h40);
        check(done_flags[2] == 1'b1, "R10", "done ch2 kept", {31'd0, done_flags[2]}, 1);
        check(exp_addr_q.size() == 0, "R4", "scoreboard empty", 32'(exp_addr_q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule